// File: doc/BRIEF.md
# Power-Management Bus Arbiter Software Channel

This block is one software-facing channel of a power-management bus arbiter. A host programs it through a small register window. For a write, the host loads the data register and then the command word. For a read, it writes the command word alone. The channel turns each accepted command into exactly one request on a downstream valid/ready port. That port stands in for the serial bus master.

Writes need no further host action. The channel goes back to idle as soon as the downstream side accepts the request.

A read parks the channel in a visible "data valid" state once the response arrives. The captured bytes stay readable in that state. The channel leaves it only when the host writes 1 to the valid-clear register. The host polls the status field for idle before it issues a command. The same valid-clear write also recovers a channel that it finds stuck holding read data.

Top module: `pmarb_swchan`

## Requirements
- R1: After synchronous active-low reset, the following all read as zero: status, command readback, write data and read data. The request valid output is also low.
- R2: The channel window starts at 0xC00 + 0x40 × channel index (default index 1, so 0xC40). The offsets inside the window are:
  - command at 0x00;
  - write data at 0x04;
  - read data at 0x14;
  - valid-clear at 0x24;
  - status at 0x28.
  Any other offset, and any address outside the window, reads as zero, and writes there have no effect.
- R3: An accepted command word drives the downstream fields from fixed bit positions:
  - class from bits 31:30;
  - write flag from bit 29 (1 = write);
  - 4-bit slave id from bits 27:24;
  - byte-count-minus-one from bits 23:16;
  - register address from bits 15:0.
  The command readback returns the accepted word with bit 28 forced to zero.
- R4: Status bits 3:1 carry the channel state; every other status bit reads zero. The encodings are:
  - 0: idle;
  - 1: request presented and not yet accepted;
  - 2: waiting for a read response;
  - 6: read data valid.
- R5: For a write, the request data equals the write-data register with byte lanes above (bits 17:16 of the command + 1) forced to zero. The channel is idle in the cycle after the request handshake, with no host acknowledge.
- R6: For a read, a response in state 2 moves the channel to state 6. It also loads the read-data register with the response, masked to the same number of little-endian byte lanes. The channel and the captured data then hold until a valid-clear; further responses are ignored.
- R7: In state 6, a write to valid-clear with bit 0 set returns the channel to idle. A write with bit 0 clear changes nothing.
- R8: A valid-clear write while the channel is not in state 6 has no effect.
- R9: A command write while the channel is not idle is ignored: the request fields and the command readback are unchanged.
- R10: Rewriting the write-data register while a request is pending does not change the data presented downstream.
- R11: While the request is valid and not accepted, valid stays high and every request field stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_addr | input | 12 | Host register address (used for both reads and writes) |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 32 | Host write bus |
| h_rdata | output | 32 | Host read bus, combinational from h_addr |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream request accepted |
| req_class | output | 2 | Command class |
| req_write | output | 1 | 1 = write, 0 = read |
| req_sid | output | 4 | Slave id |
| req_bcnt | output | 8 | Byte count minus one |
| req_addr | output | 16 | Register address on the slave |
| req_wdata | output | 32 | Masked write payload |
| rsp_valid | input | 1 | Read response strobe |
| rsp_data | input | 32 | Read response data, little-endian lanes |

## Verification
The bench sweeps all command classes, both directions and all four byte counts. It gives the byte-count field nonzero upper bits, so a design that decoded the whole field instead of its low two bits would mask the wrong lanes. Each request is held off for a varying number of cycles. During the hold-off the bench fires an illegal command, a stray valid-clear and a new write-data value. A design that re-latched on those would show changed request fields or an early state change. After a read, the bench sends a second response and a zero valid-clear. A channel that did not park in state 6 would overwrite the read data or drop to idle. Out-of-window addresses and unmapped offsets confirm that a neighbouring channel's command does not start this one.

// File: rtl/swchan_pkg.sv
// Shared types and constants for the arbiter software channel.
// Assumes a 32-bit host data bus and at most four payload byte lanes.
package swchan_pkg;

    // Channel state; the encodings are visible in status bits 3:1.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEND = 3'd1,
        ST_WAIT = 3'd2,
        ST_HOLD = 3'd6
    } ch_state_e;

    localparam int OFS_W = 6;
    localparam logic [OFS_W-1:0] OFS_CMD  = 6'h00;
    localparam logic [OFS_W-1:0] OFS_WDAT = 6'h04;
    localparam logic [OFS_W-1:0] OFS_RDAT = 6'h14;
    localparam logic [OFS_W-1:0] OFS_CLR  = 6'h24;
    localparam logic [OFS_W-1:0] OFS_STAT = 6'h28;

    // Decoded command word (bit 28 of the host word is dropped).
    typedef struct packed {
        logic [1:0]  cls;
        logic        wr;
        logic [3:0]  sid;
        logic [7:0]  bcnt;
        logic [15:0] addr;
    } cmd_t;

    // Keeps byte lanes 0..nm1 and zeroes the rest.
    function automatic logic [31:0] lane_mask(input logic [1:0] nm1);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) begin
            m[i*8 +: 8] = (i <= int'(nm1)) ? 8'hFF : 8'h00;
        end
        return m;
    endfunction

endpackage

// File: rtl/swchan_regs.sv
// Host register window of one channel: address decode, write-data storage,
// command and valid-clear strobes, and the readback multiplexer.
// Assumes the window is aligned to 2**OFS_W bytes.
module swchan_regs
    import swchan_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BANK_BASE = 32'hC00,
    parameter int CHAN_IDX  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_wr,
    input  logic [31:0]       h_wdata,
    output logic [31:0]       h_rdata,
    output logic              cmd_wr,
    output cmd_t              cmd_word,
    output logic              clr_wr,
    output logic [31:0]       wdata_q,
    input  ch_state_e         state,
    input  cmd_t              cmd_q,
    input  logic [31:0]       rdata_q
);
    localparam int STRIDE = 1 << OFS_W;
    localparam logic [ADDR_W-1:0] MY_BASE = ADDR_W'(BANK_BASE + CHAN_IDX * STRIDE);

    logic             hit;
    logic [OFS_W-1:0] off;

    // Window hit and in-window offset.
    always_comb begin
        hit = (h_addr[ADDR_W-1:OFS_W] == MY_BASE[ADDR_W-1:OFS_W]);
        off = h_addr[OFS_W-1:0];
    end

    // Write strobes toward the sequencer.
    always_comb begin
        cmd_wr   = h_wr && hit && (off == OFS_CMD);
        clr_wr   = h_wr && hit && (off == OFS_CLR) && h_wdata[0];
        cmd_word = '{cls: h_wdata[31:30], wr: h_wdata[29], sid: h_wdata[27:24],
                     bcnt: h_wdata[23:16], addr: h_wdata[15:0]};
    end

    // Write-data register, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdata_q <= '0;
        else if (h_wr && hit && (off == OFS_WDAT))
            wdata_q <= h_wdata;
    end

    // Readback multiplexer; unmapped locations return zero.
    always_comb begin
        h_rdata = '0;
        if (hit) begin
            case (off)
                OFS_CMD:  h_rdata = {cmd_q.cls, cmd_q.wr, 1'b0, cmd_q.sid, cmd_q.bcnt, cmd_q.addr};
                OFS_WDAT: h_rdata = wdata_q;
                OFS_RDAT: h_rdata = rdata_q;
                OFS_STAT: h_rdata = {28'd0, state, 1'b0};
                default:  h_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/swchan_fsm.sv
// Transfer sequencer: accepts a command in idle, presents one downstream
// request, and for reads captures and parks the response until valid-clear.
// Assumes at most one response per read request.
module swchan_fsm
    import swchan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  cmd_t        cmd_word,
    input  logic        clr_wr,
    input  logic [31:0] wdata_q,
    output ch_state_e   state,
    output cmd_t        cmd_q,
    output logic [31:0] pay_q,
    output logic [31:0] rdata_q,
    output logic        req_valid,
    input  logic        req_ready,
    input  logic        rsp_valid,
    input  logic [31:0] rsp_data
);
    // Request is presented only in the send state.
    assign req_valid = (state == ST_SEND);

    // State transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (cmd_wr)    state <= ST_SEND;
                ST_SEND: if (req_ready) state <= cmd_q.wr ? ST_IDLE : ST_WAIT;
                ST_WAIT: if (rsp_valid) state <= ST_HOLD;
                ST_HOLD: if (clr_wr)    state <= ST_IDLE;
                default:                state <= ST_IDLE;
            endcase
        end
    end

    // Snapshot of command and masked payload at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            pay_q <= '0;
        end else if (state == ST_IDLE && cmd_wr) begin
            cmd_q <= cmd_word;
            pay_q <= wdata_q & lane_mask(cmd_word.bcnt[1:0]);
        end
    end

    // Read data capture, masked to the requested byte count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (state == ST_WAIT && rsp_valid)
            rdata_q <= rsp_data & lane_mask(cmd_q.bcnt[1:0]);
    end

    p_state_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {ST_IDLE, ST_SEND, ST_WAIT, ST_HOLD});

    p_write_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cmd_q.wr) |=> (state == ST_IDLE));

    p_hold_parks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !clr_wr) |=> (state == ST_HOLD && $stable(rdata_q)));

    p_clear_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && clr_wr) |=> (state == ST_IDLE));

    p_clr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !rsp_valid && clr_wr) |=> (state == ST_WAIT));

    p_busy_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cmd_wr) |=> $stable(cmd_q));

    p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(cmd_q) && $stable(pay_q)));

endmodule

// File: rtl/pmarb_swchan.sv
// Top of one arbiter software channel: host register window plus transfer
// sequencer driving a downstream valid/ready request and response port.
// Assumes the host bus is single-cycle and that reads are combinational.
module pmarb_swchan
    import swchan_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BANK_BASE = 32'hC00,
    parameter int CHAN_IDX  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_wr,
    input  logic [31:0]       h_wdata,
    output logic [31:0]       h_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [1:0]        req_class,
    output logic              req_write,
    output logic [3:0]        req_sid,
    output logic [7:0]        req_bcnt,
    output logic [15:0]       req_addr,
    output logic [31:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_data
);
    logic        cmd_wr, clr_wr;
    cmd_t        cmd_word, cmd_q;
    logic [31:0] wdata_q, rdata_q, pay_q;
    ch_state_e   state;

    swchan_regs #(
        .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE), .CHAN_IDX(CHAN_IDX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .cmd_wr(cmd_wr),
        .cmd_word(cmd_word), .clr_wr(clr_wr), .wdata_q(wdata_q),
        .state(state), .cmd_q(cmd_q), .rdata_q(rdata_q)
    );

    swchan_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .clr_wr(clr_wr), .wdata_q(wdata_q), .state(state), .cmd_q(cmd_q),
        .pay_q(pay_q), .rdata_q(rdata_q), .req_valid(req_valid),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // Downstream request fields come from the accepted snapshot.
    always_comb begin
        req_class = cmd_q.cls;
        req_write = cmd_q.wr;
        req_sid   = cmd_q.sid;
        req_bcnt  = cmd_q.bcnt;
        req_addr  = cmd_q.addr;
        req_wdata = pay_q;
    end

endmodule

// File: tb/tb_pmarb_swchan.sv
`timescale 1ns/1ps
module tb_pmarb_swchan;
    localparam logic [11:0] B = 12'hC40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] h_addr = '0;
    logic        h_wr = 1'b0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        req_valid, req_write;
    logic        req_ready = 1'b0;
    logic [1:0]  req_class;
    logic [3:0]  req_sid;
    logic [7:0]  req_bcnt;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pmarb_swchan dut (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_class(req_class), .req_write(req_write),
        .req_sid(req_sid), .req_bcnt(req_bcnt), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
        h_addr = a; h_wdata = d; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic hread(input logic [11:0] a, output logic [31:0] d);
        h_addr = a;
        #1;
        d = h_rdata;
    endtask

    function automatic logic [31:0] keep_bytes(input logic [31:0] v, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[i*8 +: 8] = v[i*8 +: 8];
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hread(B + 12'h28, rd); chk("R1 status", rd, 0);
        hread(B + 12'h00, rd); chk("R1 cmd", rd, 0);
        hread(B + 12'h04, rd); chk("R1 wdata", rd, 0);
        hread(B + 12'h14, rd); chk("R1 rdata", rd, 0);
        chk("R1 req_valid", req_valid, 0);

        // R2 decode: neighbour channel command must not start this one
        hwrite(12'hC00, 32'h6000_0000);
        chk("R2 foreign cmd valid", req_valid, 0);
        hread(B + 12'h28, rd); chk("R2 foreign cmd status", rd, 0);
        hwrite(12'hC04, 32'h1234_5678);
        hread(B + 12'h04, rd); chk("R2 foreign wdata", rd, 0);
        hwrite(B + 12'h08, 32'hFFFF_FFFF);
        hread(B + 12'h08, rd); chk("R2 unmapped offset", rd, 0);
        hread(B + 12'h24, rd); chk("R2 clr reads zero", rd, 0);
        hread(12'hC28, rd); chk("R2 outside window", rd, 0);

        for (int cls = 0; cls < 4; cls++) begin
            for (int w = 0; w < 2; w++) begin
                for (int bc = 0; bc < 4; bc++) begin
                    logic [31:0] wd, cmd, rsp;
                    logic [7:0]  bcnt;
                    logic [3:0]  sid;
                    logic [15:0] ra;
                    int lat;
                    wd   = 32'hA1B2C3D4 + 32'(cls) * 32'h01010101 + 32'(bc);
                    bcnt = 8'(cls * 64 + bc * 4 + bc) & 8'hFC | 8'(bc);
                    sid  = 4'(cls * 4 + bc + w);
                    ra   = 16'h8000 + 16'(cls * 256 + bc * 16 + w);
                    cmd  = {2'(cls), 1'(w), 1'b1, sid, bcnt, ra};
                    lat  = (cls + bc + w) % 3;

                    hwrite(B + 12'h04, wd);
                    hwrite(B + 12'h00, cmd);
                    chk("R11 valid raised", req_valid, 1);
                    chk("R3 fields", {req_class, req_write, req_sid, req_bcnt, req_addr},
                        {2'(cls), 1'(w), sid, bcnt, ra});
                    chk("R5 masked wdata", req_wdata, keep_bytes(wd, bc + 1));
                    hread(B + 12'h00, rd); chk("R3 cmd readback", rd, cmd & 32'hEFFF_FFFF);
                    hread(B + 12'h28, rd); chk("R4 status send", rd, 32'h2);

                    // Disturbances while pending
                    hwrite(B + 12'h04, ~wd);
                    hwrite(B + 12'h00, 32'h1FFF_FFFF);
                    hwrite(B + 12'h24, 32'h1);
                    for (int k = 0; k < lat; k++) @(negedge clk);
                    chk("R11 valid held", req_valid, 1);
                    chk("R9 fields kept", {req_class, req_write, req_sid, req_bcnt, req_addr},
                        {2'(cls), 1'(w), sid, bcnt, ra});
                    chk("R10 payload kept", req_wdata, keep_bytes(wd, bc + 1));
                    hread(B + 12'h00, rd); chk("R9 cmd readback kept", rd, cmd & 32'hEFFF_FFFF);

                    req_ready = 1'b1;
                    @(negedge clk);
                    req_ready = 1'b0;
                    chk("R11 valid drops", req_valid, 0);
                    hread(B + 12'h28, rd);
                    if (w == 1) begin
                        chk("R5 write back to idle", rd, 0);
                    end else begin
                        chk("R4 status wait", rd, 32'h4);
                        hwrite(B + 12'h24, 32'h1);
                        hread(B + 12'h28, rd); chk("R8 clr ignored", rd, 32'h4);
                        rsp = 32'h5A6B7C8D ^ (32'(cls) << 8) ^ 32'(bc);
                        rsp_data = rsp; rsp_valid = 1'b1;
                        @(negedge clk);
                        rsp_valid = 1'b0;
                        hread(B + 12'h28, rd); chk("R6 status valid", rd, 32'hC);
                        hread(B + 12'h14, rd); chk("R6 rdata masked", rd, keep_bytes(rsp, bc + 1));
                        rsp_data = ~rsp; rsp_valid = 1'b1;
                        @(negedge clk);
                        rsp_valid = 1'b0;
                        hread(B + 12'h14, rd); chk("R6 rdata held", rd, keep_bytes(rsp, bc + 1));
                        hwrite(B + 12'h24, 32'hFFFF_FFFE);
                        hread(B + 12'h28, rd); chk("R7 zero clr no effect", rd, 32'hC);
                        hwrite(B + 12'h24, 32'h1);
                        hread(B + 12'h28, rd); chk("R7 clr to idle", rd, 0);
                    end
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule